// File: doc/BRIEF.md
# Eight-Entry Max-Heap Priority Queue

This block keeps up to eight 8-bit unsigned numbers and always shows the largest one on its `root` output. A client can add a number or take out the current maximum. Each request passes through a ready/valid handshake. The values sit in an array laid out as a binary max-heap, where the children of slot i are at slots 2i+1 and 2i+2.

An insert writes the new value into the first free slot and then moves it upward. A removal copies the last occupied slot into slot 0 and then moves that value downward. Each of these sift steps is one compare-and-swap per clock cycle. `ready` is low while the block is sifting. When `ready` rises again, every output shows the result of the finished operation. The `empty` and `full` flags report when the queue holds no values or all eight.

Top module: `maxheap_pq`

## Requirements
- R1: After reset, `ready` is 1, `empty` is 1, `full` is 0 and `root` is 0.
- R2: `op_code` = 0 means insert. An accepted insert adds `new_val` to the stored set. Whenever `ready` is 1 and the queue is not empty, `root` equals the largest stored value.
- R3: `op_code` = 1 means remove. An accepted remove takes exactly one copy of the largest stored value out of the set.
- R4: `empty` is 1 exactly when no values are stored. It is never high at the same time as `full`.
- R5: `full` is 1 exactly when eight values are stored. It is 0 once a remove on a full queue has completed.
- R6: An insert offered while `full` is 1 leaves the stored values unchanged, and `ready` stays 1 in the next cycle.
- R7: A remove offered while `empty` is 1 changes nothing, and `ready` is 1 in the next cycle.
- R8: While `ready` is 0, `op_valid`, `op_code` and `new_val` have no effect on the stored values.
- R9: An operation starts only in a cycle where `op_valid` and `ready` are both 1. After an accepted insert or remove, `ready` is 0 for at least one cycle, then returns to 1 within a bounded number of cycles.
- R10: Equal values are each kept. Inserting a value equal to one already stored adds a second copy, and each copy is removed separately.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_valid | input | 1 | Operation request |
| op_code | input | 1 | 0 = insert, 1 = remove maximum |
| new_val | input | 8 | Value to insert |
| ready | output | 1 | Idle; accepts a request; outputs are stable |
| root | output | 8 | Largest stored value, 0 when empty |
| empty | output | 1 | No values stored |
| full | output | 1 | Eight values stored |

## Verification
The bench compares the block against a behavioural multiset on every idle cycle. It aims at the boundaries of the queue.

- It inserts into a full queue using a value larger than any stored one. A design that wrote the value anyway would show it on `root`.
- It removes from an empty queue. A design that decremented the count anyway would wrap it and raise a false `full`.
- It repeats values, including runs of duplicates. A design that stopped sifting wrongly or dropped copies would present a wrong maximum or empty too early.
- It asserts random requests while `ready` is low. A design that listened during its sift cycles would gain or lose entries.

// File: rtl/maxheap_pq.sv
module maxheap_pq #(
  parameter int DW    = 8,
  parameter int DEPTH = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          op_valid,
  input  logic          op_code,
  input  logic [DW-1:0] new_val,
  output logic          ready,
  output logic [DW-1:0] root,
  output logic          empty,
  output logic          full
);
  localparam int CW = $clog2(DEPTH + 1);
  localparam int IW = $clog2(DEPTH);

  typedef enum logic [1:0] {ST_IDLE, ST_UP, ST_DOWN} state_t;

  state_t         state;
  logic [DW-1:0]  heap [DEPTH];
  logic [CW-1:0]  count;
  logic [IW-1:0]  idx;

  logic [IW-1:0]  parent, last, big;
  logic [IW+1:0]  lft, rgt;
  logic           lft_ok, rgt_ok, take_ins, take_rem;

  assign ready  = (state == ST_IDLE);
  assign empty  = (count == '0);
  assign full   = (count == CW'(DEPTH));
  assign root   = empty ? '0 : heap[0];

  assign parent = (idx - IW'(1)) >> 1;
  assign last   = IW'(count - CW'(1));
  assign lft    = {1'b0, idx, 1'b1};
  assign rgt    = lft + (IW+2)'(1);
  assign lft_ok = lft < (IW+2)'(count);
  assign rgt_ok = rgt < (IW+2)'(count);
  assign big    = (rgt_ok && heap[rgt[IW-1:0]] > heap[lft[IW-1:0]]) ? rgt[IW-1:0] : lft[IW-1:0];

  assign take_ins = ready && op_valid && !op_code && !full;
  assign take_rem = ready && op_valid &&  op_code && !empty;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      count <= '0;
      idx   <= '0;
      for (int i = 0; i < DEPTH; i++) heap[i] <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (take_ins) begin
            heap[IW'(count)] <= new_val;
            idx   <= IW'(count);
            count <= count + CW'(1);
            state <= ST_UP;
          end else if (take_rem) begin
            heap[0] <= heap[last];
            idx   <= '0;
            count <= count - CW'(1);
            state <= ST_DOWN;
          end
        end
        ST_UP: begin
          if (idx != '0 && heap[idx] > heap[parent]) begin
            heap[idx]    <= heap[parent];
            heap[parent] <= heap[idx];
            idx          <= parent;
          end else begin
            state <= ST_IDLE;
          end
        end
        ST_DOWN: begin
          if (lft_ok && heap[big] > heap[idx]) begin
            heap[idx] <= heap[big];
            heap[big] <= heap[idx];
            idx       <= big;
          end else begin
            state <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(empty && full)); // R4

  AST_ACCEPT_GOES_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && op_valid && ((!op_code && !full) || (op_code && !empty))) |=> !ready); // R9

  AST_FULL_INSERT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && op_valid && !op_code && full) |=> (ready && full && $stable(root))); // R6

  AST_EMPTY_REMOVE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && op_valid && op_code && empty) |=> (ready && empty)); // R7

  AST_REMOVE_CLEARS_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && op_valid && op_code && full) |=> !full); // R5

  AST_BUSY_FLAGS_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !ready |=> ($stable(empty) && $stable(full))); // R8

  for (genvar g = 1; g < DEPTH; g++) begin : g_root_chk
    AST_ROOT_IS_MAX: assert property (@(posedge clk) disable iff (!rst_n)
      (ready && CW'(g) < count) |-> (heap[0] >= heap[g])); // R2
  end
endmodule

// File: tb/maxheap_pq_tb.sv
module maxheap_pq_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       op_valid = 1'b0;
  logic       op_code = 1'b0;
  logic [7:0] new_val = '0;
  logic       ready, empty, full;
  logic [7:0] root;

  int checks = 0;
  int fails  = 0;
  int busy_run = 0;
  int model [$];

  always #10 clk = ~clk;

  maxheap_pq u_dut (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
    .new_val(new_val), .ready(ready), .root(root), .empty(empty), .full(full)
  );

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int model_max();
    int m = 0;
    foreach (model[i]) if (model[i] > m) m = model[i];
    return m;
  endfunction

  task automatic model_apply(bit o, int d);
    if (!o) begin
      if (model.size() < 8) model.push_back(d);
    end else if (model.size() > 0) begin
      int mi = 0;
      foreach (model[i]) if (model[i] > model[mi]) mi = i;
      model.delete(mi);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  task automatic compare_idle();
    if (ready) begin
      busy_run = 0;
      check(root == 8'(model_max()), "R2/R3 root", root, model_max());
      check(empty == (model.size() == 0), "R4 empty", empty, model.size() == 0);
      check(full == (model.size() == 8), "R5 full", full, model.size() == 8);
    end else begin
      busy_run++;
      if (busy_run > 20) begin
        check(1'b0, "R9 ready stuck low", 0, 1);
        finish_run();
      end
    end
  endtask

  task automatic cyc(bit v, bit o, logic [7:0] d);
    compare_idle();
    op_valid = v; op_code = o; new_val = d;
    if (v && ready) model_apply(o, d);
    @(negedge clk);
  endtask

  task automatic issue(bit o, logic [7:0] d, bit noise);
    bit real_op;
    while (!ready) cyc(noise && ($urandom_range(0, 1) == 1), 1'($urandom_range(0, 1)), 8'($urandom_range(0, 255)));
    real_op = o ? (model.size() > 0) : (model.size() < 8);
    cyc(1'b1, o, d);
    op_valid = 1'b0;
    if (real_op) check(!ready, "R9 busy after accept", ready, 0);
    else check(ready, o ? "R7 ready after empty remove" : "R6 ready after full insert", ready, 1);
  endtask

  task automatic settle();
    while (!ready) cyc(1'b0, 1'b0, 8'h00);
    compare_idle();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    check(1'b0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    check(ready && empty && !full && root == 0, "R1 reset", {ready, empty, full}, 3'b110);
    rst_n = 1'b1;
    @(negedge clk);
    check(ready && empty && !full && root == 0, "R1 after release", root, 0);

    issue(1'b1, 8'h00, 1'b0);
    check(empty && !full, "R7 empty remove", {empty, full}, 2'b10);
    settle();

    for (int i = 0; i < 8; i++) issue(1'b0, 8'(10 + i * 7), 1'b0);
    settle();
    check(full, "R5 full after eight", full, 1);

    issue(1'b0, 8'hFF, 1'b0);
    settle();
    check(root == 8'(10 + 49), "R6 root unchanged", root, 59);
    issue(1'b0, 8'hFE, 1'b0);

    issue(1'b1, 8'h00, 1'b0);
    settle();
    check(!full, "R5 full clears", full, 0);

    for (int i = 0; i < 7; i++) issue(1'b1, 8'h00, 1'b0);
    settle();
    check(empty, "R4 empty after drain", empty, 1);

    for (int i = 0; i < 6; i++) issue(1'b0, (i % 2 == 0) ? 8'd40 : 8'd90, 1'b0);
    issue(1'b0, 8'd90, 1'b0);
    settle();
    for (int i = 0; i < 7; i++) begin
      issue(1'b1, 8'h00, 1'b0);
      settle();
      check(empty == (i == 6), "R10 duplicates kept", empty, i == 6);
    end

    for (int i = 0; i < 8; i++) issue(1'b0, 8'(200 - i * 20), 1'b1);
    for (int i = 0; i < 8; i++) issue(1'b1, 8'h00, 1'b1);
    settle();
    check(empty, "R8 busy noise ignored", empty, 1);

    for (int n = 0; n < 3000; n++) begin
      bit o = ($urandom_range(0, 99) < 45);
      issue(o, 8'($urandom_range(0, 15) * 17 % 256), 1'b1);
    end
    settle();
    while (model.size() > 0) issue(1'b1, 8'h00, 1'b1);
    settle();
    check(empty && root == 0, "R4 final drain", root, 0);
    finish_run();
  end
endmodule